// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre-Slot Voting

This block takes one asynchronous, idle-high serial line and turns each received character into a parallel word. It divides the system clock down to sixteen slot ticks per bit period and restarts all of its timing on every falling edge that opens a frame. Each bit is decided by a 2-of-3 majority over the three centre slots of that bit, so one stray sample near the middle of a bit cannot flip it.

A frame is a low start bit, the data bits with the least significant bit first, one parity bit and one high stop bit. When a frame completes, the word and two error flags (parity mismatch and low stop bit) are loaded together and a single-cycle strobe marks them. They then hold until the next frame completes. A start that no longer reads low at mid-bit is treated as noise and dropped without a strobe.

The baud rate, the clock frequency, the data width, the parity sense and the depth of the input synchronizer are parameters. The slot divider is round(CLK_HZ / (16 × BAUD)).

Top module: `vrx_serial_rx`

## Requirements
- R1: The slot divider is DIV = round(CLK_HZ / (OVS × BAUD)). For a frame at the exact rate, rx_valid is high on the clock edge 11 × OVS × DIV + 3 cycles after the first edge that sees rx_in low.
- R2: Each bit value is the majority of the synchronized line sampled in slots 7, 8 and 9 of the 0..15 slot count. One disagreeing sample among the three leaves the bit unchanged. Two disagreeing samples invert it.
- R3: In idle, a falling edge on the synchronized line clears the slot and bit counters and the divider phase. Falling edges inside a frame (before the stop bit's centre samples) do not restart it.
- R4: A frame is 1 start bit (low), DATA_BITS data bits sent least significant bit first, 1 parity bit and 1 stop bit (high). The data bits appear on rx_data with bit i equal to the i-th data bit sent.
- R5: If the voted start bit is high, the receiver returns to idle. It raises no rx_valid and leaves rx_data and the flags unchanged, and it accepts the next proper frame.
- R6: rx_parity_err is 1 when the parity bit differs from the XOR of the data bits (ODD_PARITY=0, even) or from its complement (ODD_PARITY=1, odd).
- R7: rx_frame_err is 1 when the voted stop bit is low, and 0 when it is high.
- R8: After reset, rx_data, rx_valid, rx_parity_err and rx_frame_err are 0. rx_valid is a single-cycle pulse. rx_data and both flags change only in a cycle where rx_valid is 1.
- R9: Frames whose bit period is off by about ±1.6% from nominal are received without error.
- R10: Once the stop bit's centre samples are taken, a new falling edge completes the current frame at once (rx_valid) and starts the next. Frames sent back to back with no idle time are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | DATA_BITS | Last received data word |
| rx_valid | output | 1 | One-cycle strobe: a frame has completed |
| rx_parity_err | output | 1 | Parity mismatch of the last frame |
| rx_frame_err | output | 1 | Stop bit of the last frame was low |

## Verification
The hardest states to reach are the ones where the three centre samples of one bit disagree, and the ones where a new start edge lands while the stop bit is still being timed. The stimulus drives the line with per-slot timing: it inverts one or two of the sampled slots inside every data bit to show the vote at work. It also shortens the bit period and sends frames with no idle gap, so the next start edge lands inside the late part of the stop bit. Short start glitches and deliberately bad parity and stop bits cover the error paths.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } vrx_state_e;

   // 2-of-3 majority
   function automatic logic vote3(input logic [2:0] s);
      return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
   endfunction

endpackage

// File: rtl/vrx_tick_gen.sv
module vrx_tick_gen #(
   parameter int unsigned DIV = 68
) (
   input  logic clk,
   input  logic rst_n,
   input  logic realign,
   output logic tick
);

   generate
      if (DIV <= 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (realign || cnt_q == LAST)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/vrx_line_sync.sv
module vrx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_async,
   output logic rx_line,
   output logic rx_fall
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], rx_async};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rx_line = chain_q[STAGES-1];
   assign rx_fall = prev_q & ~rx_line;

endmodule

// File: rtl/vrx_vote.sv
module vrx_vote #(
   parameter int unsigned OVS = 16,
   parameter int unsigned SW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [SW-1:0] slot,
   input  logic          line,
   output logic          vote
);

   logic [2:0] smp_q;

   // samples taken in slots OVS/2-1, OVS/2, OVS/2+1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= 3'b111;
      end else if (tick) begin
         for (int k = 0; k < 3; k++) begin
            if (slot == SW'(OVS / 2 - 1 + k))
               smp_q[k] <= line;
         end
      end
   end

   assign vote = vrx_pkg::vote3(smp_q);

endmodule

// File: rtl/vrx_frame_fsm.sv
module vrx_frame_fsm
   import vrx_pkg::*;
#(
   parameter int unsigned OVS        = 16,
   parameter int unsigned DATA_BITS  = 8,
   parameter bit          ODD_PARITY = 1'b0,
   parameter int unsigned SW         = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 fall,
   input  logic                 vote,
   output logic [SW-1:0]        slot,
   output logic                 realign,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 perr_o,
   output logic                 ferr_o
);

   localparam int unsigned     BW         = $clog2(DATA_BITS + 1);
   localparam logic [SW-1:0]   LAST_SLOT  = SW'(OVS - 1);
   localparam logic [SW-1:0]   CHECK_SLOT = SW'(OVS / 2 + 2);
   localparam logic [BW-1:0]   LAST_BIT   = BW'(DATA_BITS - 1);

   vrx_state_e           state_q;
   logic [SW-1:0]        slot_q;
   logic [BW-1:0]        bit_q;
   logic [DATA_BITS-1:0] shift_q;
   logic                 par_q;
   logic                 expect_par;
   logic                 stop_seen;

   generate
      if (ODD_PARITY) begin : g_odd
         assign expect_par = ~(^shift_q);
      end else begin : g_even
         assign expect_par = ^shift_q;
      end
   endgenerate

   assign stop_seen = (state_q == ST_STOP) && (slot_q >= CHECK_SLOT);
   assign realign   = fall && ((state_q == ST_IDLE) || stop_seen);
   assign slot      = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         bit_q   <= '0;
         shift_q <= '0;
         par_q   <= 1'b0;
         data_o  <= '0;
         valid_o <= 1'b0;
         perr_o  <= 1'b0;
         ferr_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (realign) begin
            if (state_q == ST_STOP) begin
               data_o  <= shift_q;
               perr_o  <= par_q ^ expect_par;
               ferr_o  <= ~vote;
               valid_o <= 1'b1;
            end
            state_q <= ST_START;
            slot_q  <= '0;
            bit_q   <= '0;
         end else if (tick && state_q != ST_IDLE) begin
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            unique case (state_q)
               ST_START: begin
                  if (slot_q == CHECK_SLOT && vote)
                     state_q <= ST_IDLE;
                  else if (slot_q == LAST_SLOT)
                     state_q <= ST_DATA;
               end
               ST_DATA: begin
                  if (slot_q == LAST_SLOT) begin
                     shift_q <= {vote, shift_q[DATA_BITS-1:1]};
                     if (bit_q == LAST_BIT)
                        state_q <= ST_PARITY;
                     else
                        bit_q <= bit_q + 1'b1;
                  end
               end
               ST_PARITY: begin
                  if (slot_q == LAST_SLOT) begin
                     par_q   <= vote;
                     state_q <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (slot_q == LAST_SLOT) begin
                     data_o  <= shift_q;
                     perr_o  <= par_q ^ expect_par;
                     ferr_o  <= ~vote;
                     valid_o <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_REALIGN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && fall) |=> (state_q == ST_START && slot_q == '0)); // R3

   AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START && tick && slot_q == CHECK_SLOT && vote) |=> (state_q == ST_IDLE)); // R5

   AST_STOP_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP && tick && slot_q == LAST_SLOT) |=> valid_o); // R8

endmodule

// File: rtl/vrx_serial_rx.sv
module vrx_serial_rx
   import vrx_pkg::*;
#(
   parameter longint unsigned CLK_HZ      = 125_000_000,
   parameter longint unsigned BAUD        = 115_200,
   parameter int unsigned     OVS         = 16,
   parameter int unsigned     DATA_BITS   = 8,
   parameter bit              ODD_PARITY  = 1'b0,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_in,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 rx_parity_err,
   output logic                 rx_frame_err
);

   localparam longint unsigned SLOT_RATE = longint'(OVS) * BAUD;
   localparam int unsigned     DIV       = int'((CLK_HZ + SLOT_RATE / 2) / SLOT_RATE);
   localparam int unsigned     SW        = $clog2(OVS);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_width
         $error("DATA_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DIV < 1) begin : g_bad_div
         $error("clock too slow for requested baud rate");
      end
   endgenerate

   logic          tick;
   logic          realign;
   logic          line;
   logic          fall;
   logic          vote;
   logic [SW-1:0] slot;

   vrx_tick_gen #(.DIV(DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .realign (realign),
      .tick    (tick)
   );

   vrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_async (rx_in),
      .rx_line  (line),
      .rx_fall  (fall)
   );

   vrx_vote #(.OVS(OVS), .SW(SW)) u_vote (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .slot  (slot),
      .line  (line),
      .vote  (vote)
   );

   vrx_frame_fsm #(
      .OVS        (OVS),
      .DATA_BITS  (DATA_BITS),
      .ODD_PARITY (ODD_PARITY),
      .SW         (SW)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .fall    (fall),
      .vote    (vote),
      .slot    (slot),
      .realign (realign),
      .data_o  (rx_data),
      .valid_o (rx_valid),
      .perr_o  (rx_parity_err),
      .ferr_o  (rx_frame_err)
   );

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R8

   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable({rx_data, rx_parity_err, rx_frame_err})); // R8

endmodule

// File: tb/vrx_serial_rx_test.sv
module vrx_serial_rx_test;

   localparam longint unsigned CLK_HZ = 125_000_000;
   localparam longint unsigned BAUD   = 1_953_125;
   localparam int DIV = 4;
   localparam int BIT = 16 * DIV;
   localparam int LAT = 11 * BIT + 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic [7:0] rx_data, odd_data;
   logic       rx_valid, rx_perr, rx_ferr;
   logic       odd_valid, odd_perr, odd_ferr;

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   int start_cyc = 0;

   int         cap_n = 0;
   logic [7:0] cap_data [0:7];
   logic       cap_perr [0:7];
   logic       cap_ferr [0:7];
   int         cap_cyc  [0:7];
   int         dbl_valid = 0;
   logic       prev_valid = 1'b0;
   int         odd_n = 0;
   logic       odd_perr_last = 1'b0;

   always #4 clk = ~clk;

   vrx_serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .rx_in(rx), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_parity_err(rx_perr), .rx_frame_err(rx_ferr)
   );

   vrx_serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ODD_PARITY(1'b1)) uut_odd (
      .clk(clk), .rst_n(rst_n), .rx_in(rx), .rx_data(odd_data),
      .rx_valid(odd_valid), .rx_parity_err(odd_perr), .rx_frame_err(odd_ferr)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rx_valid) begin
         cap_data[cap_n % 8] = rx_data;
         cap_perr[cap_n % 8] = rx_perr;
         cap_ferr[cap_n % 8] = rx_ferr;
         cap_cyc[cap_n % 8]  = cyc;
         cap_n = cap_n + 1;
      end
      if (rx_valid && prev_valid) dbl_valid = dbl_valid + 1;
      prev_valid = rx_valid;
      if (odd_valid) begin
         odd_perr_last = odd_perr;
         odd_n = odd_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   // one frame; ninv>0 inverts that many slots from slot 9 inside every data bit
   task automatic send(input logic [7:0] d, input logic pbit, input logic stopb,
                       input int blen, input int ninv);
      start_cyc = cyc;
      drive(1'b0, blen);
      for (int i = 0; i < 8; i++) begin
         if (ninv == 0) begin
            drive(d[i], blen);
         end else begin
            drive(d[i], 9 * DIV);
            drive(~d[i], ninv * DIV);
            drive(d[i], blen - (9 + ninv) * DIV);
         end
      end
      drive(pbit, blen);
      drive(stopb, blen);
      rx = 1'b1;
   endtask

   task automatic t_reset();
      check(rx_valid == 1'b0, "R8 reset valid", int'(rx_valid), 0);
      check(rx_data == 8'h00, "R8 reset data", int'(rx_data), 0);
      check(rx_perr == 1'b0 && rx_ferr == 1'b0, "R8 reset flags",
            int'({rx_perr, rx_ferr}), 0);
   endtask

   task automatic t_basic();
      logic [7:0] pats [0:3];
      pats[0] = 8'hA5; pats[1] = 8'h55; pats[2] = 8'h00; pats[3] = 8'hFF;
      for (int i = 0; i < 4; i++) begin
         int n0;
         n0 = cap_n;
         send(pats[i], ^pats[i], 1'b1, BIT, 0);
         drive(1'b1, 2 * BIT);
         // 0x55 carries falling edges mid-frame: R3 no restart
         check(cap_n == n0 + 1, "R3 one frame per start", cap_n - n0, 1);
         check(cap_data[n0 % 8] == pats[i], "R4 data LSB first",
               int'(cap_data[n0 % 8]), int'(pats[i]));
         check(cap_perr[n0 % 8] == 1'b0, "R6 even parity ok", int'(cap_perr[n0 % 8]), 0);
         check(cap_ferr[n0 % 8] == 1'b0, "R7 stop high", int'(cap_ferr[n0 % 8]), 0);
      end
   endtask

   task automatic t_latency_hold();
      int n0;
      n0 = cap_n;
      send(8'h3C, ^8'h3C, 1'b1, BIT, 0);
      drive(1'b1, 3 * BIT);
      check(cap_cyc[n0 % 8] - start_cyc == LAT, "R1 frame latency",
            cap_cyc[n0 % 8] - start_cyc, LAT);
      check(rx_valid == 1'b0 && rx_data == 8'h3C, "R8 data held after pulse",
            int'(rx_data), 8'h3C);
   endtask

   task automatic t_majority();
      int n0;
      n0 = cap_n;
      send(8'h96, ^8'h96, 1'b1, BIT, 1);
      drive(1'b1, 2 * BIT);
      check(cap_data[n0 % 8] == 8'h96, "R2 one bad sample outvoted",
            int'(cap_data[n0 % 8]), 8'h96);
      n0 = cap_n;
      send(8'h96, ^8'h96, 1'b1, BIT, 2);
      drive(1'b1, 2 * BIT);
      check(cap_data[n0 % 8] == 8'h69, "R2 two bad samples win",
            int'(cap_data[n0 % 8]), 8'h69);
   endtask

   task automatic t_parity();
      int n0;
      n0 = cap_n;
      send(8'h5A, ~(^8'h5A), 1'b1, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(cap_perr[n0 % 8] == 1'b1, "R6 even parity error", int'(cap_perr[n0 % 8]), 1);
      check(cap_data[n0 % 8] == 8'h5A, "R6 data with parity error",
            int'(cap_data[n0 % 8]), 8'h5A);
      check(odd_perr_last == 1'b0, "R6 odd parity ok", int'(odd_perr_last), 0);
      send(8'h5A, ^8'h5A, 1'b1, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(odd_perr_last == 1'b1, "R6 odd parity error", int'(odd_perr_last), 1);
      check(rx_perr == 1'b0, "R6 even parity clear", int'(rx_perr), 0);
   endtask

   task automatic t_framing();
      int n0;
      n0 = cap_n;
      send(8'hE7, ^8'hE7, 1'b0, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(cap_ferr[n0 % 8] == 1'b1, "R7 low stop flagged", int'(cap_ferr[n0 % 8]), 1);
      check(cap_data[n0 % 8] == 8'hE7, "R7 data kept", int'(cap_data[n0 % 8]), 8'hE7);
      n0 = cap_n;
      send(8'h18, ^8'h18, 1'b1, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(cap_ferr[n0 % 8] == 1'b0, "R7 flag clears", int'(cap_ferr[n0 % 8]), 0);
   endtask

   task automatic t_glitch();
      int n0;
      n0 = cap_n;
      drive(1'b0, 3 * DIV);
      drive(1'b1, 12 * BIT);
      check(cap_n == n0, "R5 glitch gives no frame", cap_n - n0, 0);
      check(rx_data == 8'h18, "R5 data unchanged", int'(rx_data), 8'h18);
      send(8'h81, ^8'h81, 1'b1, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(cap_n == n0 + 1 && cap_data[n0 % 8] == 8'h81, "R5 next frame accepted",
            int'(cap_data[n0 % 8]), 8'h81);
   endtask

   task automatic t_drift();
      int n0;
      n0 = cap_n;
      send(8'hC3, ^8'hC3, 1'b1, BIT - 1, 0);
      drive(1'b1, 2 * BIT);
      check(cap_data[n0 % 8] == 8'hC3 && !cap_ferr[n0 % 8], "R9 fast sender",
            int'(cap_data[n0 % 8]), 8'hC3);
      n0 = cap_n;
      send(8'h3C, ^8'h3C, 1'b1, BIT + 1, 0);
      drive(1'b1, 2 * BIT);
      check(cap_data[n0 % 8] == 8'h3C && !cap_ferr[n0 % 8], "R9 slow sender",
            int'(cap_data[n0 % 8]), 8'h3C);
   endtask

   task automatic t_back_to_back();
      int n0;
      n0 = cap_n;
      send(8'h11, ^8'h11, 1'b1, BIT - 1, 0);
      send(8'h22, ^8'h22, 1'b1, BIT - 1, 0);
      drive(1'b1, 2 * BIT);
      check(cap_n == n0 + 2, "R10 two fast frames", cap_n - n0, 2);
      check(cap_data[n0 % 8] == 8'h11, "R10 first frame", int'(cap_data[n0 % 8]), 8'h11);
      check(cap_data[(n0 + 1) % 8] == 8'h22, "R10 second frame",
            int'(cap_data[(n0 + 1) % 8]), 8'h22);
      n0 = cap_n;
      send(8'h33, ^8'h33, 1'b1, BIT, 0);
      send(8'h44, ^8'h44, 1'b1, BIT, 0);
      drive(1'b1, 2 * BIT);
      check(cap_n == n0 + 2 && cap_data[(n0 + 1) % 8] == 8'h44, "R10 nominal no gap",
            int'(cap_data[(n0 + 1) % 8]), 8'h44);
      check(dbl_valid == 0, "R8 valid single cycle", dbl_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      drive(1'b1, BIT);
      t_reset();
      t_basic();
      t_latency_hold();
      t_majority();
      t_parity();
      t_framing();
      t_glitch();
      t_drift();
      t_back_to_back();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule